// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block sits between a host that issues single-bit read and write requests with a full word address and a one-bit-wide dynamic RAM whose address pins are only half the width of that address. It holds the request, shows the upper half of the address on the shared pins and lowers the row strobe. It then switches an internal 2:1 selector to the lower half and lowers the column strobe. The bit moves over separate data-in and data-out pins.

A request is taken only when the controller is idle. Every access ends with both strobes high. A precharge interval, counted in clock cycles, follows every access. The host learns that an access has finished from a one-cycle ready pulse, and read data is valid during that pulse. Parameters set the address width, the read sampling delay after the column strobe falls, and the precharge length.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, ras_no, cas_no and we_no are high and ready_o is low.
- R2: The row half, addr_i[ADDR_W-1:ADDR_W/2], is on dram_addr_o for at least one cycle before ras_no falls and while it falls.
- R3: The column half, addr_i[ADDR_W/2-1:0], replaces the row at least one cycle after ras_no falls and stays at least one cycle before cas_no falls. cas_no is low only while ras_no is low.
- R4: For a write (we_i=1), we_no is low and din_o equals wdata_i from at least one cycle before cas_no falls until cas_no rises. The bit is stored at the row/column pair.
- R5: For a read (we_i=0), we_no stays high. dout_i is sampled at the CAS_LAT-th clock edge after the edge on which cas_no falls.
- R6: ready_o is high for exactly one cycle, starting CAS_LAT+3 edges after the edge that accepts req_i. rdata_o holds the read bit during that cycle.
- R7: Both strobes are high while ready_o is high. The next ras_no fall comes no earlier than T_PRE+3 edges after ready_o rises.
- R8: req_i asserted while an access is in progress is ignored. It starts no strobe and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Full word address |
| wdata_i | input | 1 | Write bit |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 1 | Read bit, valid with ready_o |
| dram_addr_o | output | ADDR_W/2 | Shared row/column address pins |
| ras_no | output | 1 | Row address strobe, active low |
| cas_no | output | 1 | Column address strobe, active low |
| we_no | output | 1 | Write enable, active low |
| din_o | output | 1 | Data to the memory |
| dout_i | input | 1 | Data from the memory |

## Verification
The bench samples on falling clock edges and counts them from the one on which it raises req_i.

Timing of each result, counted in falling edges:
- ras_no is low from the second one.
- cas_no is low from the fourth one.
- ready_o is high on edge CAS_LAT+4 and low again on the next.
- After a back-to-back request, ras_no falls again T_PRE+3 edges after the ready edge.

The memory model in the bench returns the true bit only on the single cycle when the controller should sample it, and the inverted bit at all other times. A read therefore passes only if the sampling delay is exactly right.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_RAS, ST_COL, ST_CAS, ST_DONE, ST_PRE
  } seq_state_e;
endpackage

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int HALF_W = 8
) (
  input  logic [HALF_W-1:0] row_i,
  input  logic [HALF_W-1:0] col_i,
  input  logic              sel_col_i,
  output logic [HALF_W-1:0] addr_o
);
  assign addr_o = sel_col_i ? col_i : row_i;
endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic dout_i,
  output logic rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= 1'b0;
    else if (en_i) rdata_o <= dout_i;
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctrl_pkg::*;
#(
  parameter int CAS_LAT = 2,
  parameter int T_PRE   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic ras_no,
  output logic cas_no,
  output logic sel_col_o,
  output logic we_phase_o,
  output logic capture_o,
  output logic ready_o
);
  localparam int CNT_MAX = (CAS_LAT > T_PRE) ? CAS_LAT : T_PRE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) state_q <= ST_ROW;
        ST_ROW:  state_q <= ST_RAS;
        ST_RAS:  state_q <= ST_COL;
        ST_COL: begin
          state_q <= ST_CAS;
          cnt_q   <= CNT_W'(CAS_LAT - 1);
        end
        ST_CAS: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_DONE: begin
          state_q <= ST_PRE;
          cnt_q   <= CNT_W'(T_PRE - 1);
        end
        ST_PRE: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign accept_o   = (state_q == ST_IDLE) && req_i;
  assign ras_no     = !(state_q inside {ST_RAS, ST_COL, ST_CAS});
  assign cas_no     = !(state_q == ST_CAS);
  assign sel_col_o  = state_q inside {ST_COL, ST_CAS};
  assign we_phase_o = state_q inside {ST_COL, ST_CAS};
  assign capture_o  = (state_q == ST_CAS) && (cnt_q == '0);
  assign ready_o    = (state_q == ST_DONE);
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ADDR_W  = 16,
  parameter int CAS_LAT = 2,
  parameter int T_PRE   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wdata_i,
  output logic                ready_o,
  output logic                rdata_o,
  output logic [ADDR_W/2-1:0] dram_addr_o,
  output logic                ras_no,
  output logic                cas_no,
  output logic                we_no,
  output logic                din_o,
  input  logic                dout_i
);
  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic              we_q, wdata_q;
  logic              accept, sel_col, we_phase, capture;

  dram_seq #(.CAS_LAT(CAS_LAT), .T_PRE(T_PRE)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .accept_o   (accept),
    .ras_no     (ras_no),
    .cas_no     (cas_no),
    .sel_col_o  (sel_col),
    .we_phase_o (we_phase),
    .capture_o  (capture),
    .ready_o    (ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  // upper half is the row, lower half the column
  dram_addr_mux #(.HALF_W(HALF_W)) u_mux (
    .row_i     (addr_q[ADDR_W-1:HALF_W]),
    .col_i     (addr_q[HALF_W-1:0]),
    .sel_col_i (sel_col),
    .addr_o    (dram_addr_o)
  );

  dram_rd_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (capture && !we_q),
    .dout_i  (dout_i),
    .rdata_o (rdata_o)
  );

  assign we_no = !(we_phase && we_q);
  assign din_o = wdata_q;
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int T_PRE  = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ras_no,
  input logic                cas_no,
  input logic                we_no,
  input logic                din_o,
  input logic                ready_o,
  input logic [ADDR_W/2-1:0] dram_addr_o
);
  localparam int HW = $clog2(T_PRE + 1);
  logic [HW:0] hi_cnt;

  // consecutive sampled-high cycles of ras_no, saturating at T_PRE
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hi_cnt <= (HW+1)'(T_PRE);
    else if (!ras_no)                 hi_cnt <= '0;
    else if (hi_cnt < (HW+1)'(T_PRE)) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_row_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $stable(dram_addr_o));
  assert_cas_in_ras_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> !ras_no);
  assert_col_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> ($past(!ras_no) && $stable(dram_addr_o)));
  assert_we_din_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> ($stable(we_no) && $stable(din_o)));
  assert_ready_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_strobes_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ras_no && cas_no));
  assert_precharge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> (hi_cnt >= (HW+1)'(T_PRE)));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.ADDR_W(ADDR_W), .T_PRE(T_PRE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ras_no      (ras_no),
  .cas_no      (cas_no),
  .we_no       (we_no),
  .din_o       (din_o),
  .ready_o     (ready_o),
  .dram_addr_o (dram_addr_o)
);

// File: tb/tb_dram_mux_ctrl.sv
`timescale 1ns/1ps
module tb_dram_mux_ctrl;
  localparam int ADDR_W  = 16;
  localparam int HALF_W  = ADDR_W / 2;
  localparam int CAS_LAT = 2;
  localparam int T_PRE   = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, wdata_i = 1'b0, dout_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic ready_o, rdata_o, ras_no, cas_no, we_no, din_o;
  logic [HALF_W-1:0] dram_addr_o;

  int checks = 0, failures = 0;

  always #2 clk_i = ~clk_i;

  dram_mux_ctrl #(.ADDR_W(ADDR_W), .CAS_LAT(CAS_LAT), .T_PRE(T_PRE)) dut (.*);

  // memory model: true bit only on the cycle the controller should sample it
  bit mem [int unsigned];
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [HALF_W-1:0] m_row = '0, m_col = '0;
  int cas_cnt = 0, ras_falls = 0, writes = 0;

  function automatic bit stored(logic [ADDR_W-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 1'b0;
  endfunction

  always @(negedge clk_i) begin
    if (prev_ras && !ras_no) begin
      m_row = dram_addr_o;
      ras_falls++;
    end
    if (prev_cas && !cas_no) begin
      m_col = dram_addr_o;
      if (!we_no) begin
        mem[int'({m_row, dram_addr_o})] = din_o;
        writes++;
      end
    end
    cas_cnt = cas_no ? 0 : cas_cnt + 1;
    dout_i  = (!cas_no && cas_cnt == CAS_LAT) ? stored({m_row, m_col}) : !stored({m_row, m_col});
    prev_ras = ras_no;
    prev_cas = cas_no;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    repeat (T_PRE + 3) @(negedge clk_i);
  endtask

  task automatic access(input bit we, input logic [ADDR_W-1:0] a, input bit d, input bit exp_rd);
    int n = 0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1) req_i = 1'b0;
    end while (!ready_o && n < 60);
    chk(n == CAS_LAT + 4, "R6 ready latency", n, CAS_LAT + 4);
    chk(m_row == a[ADDR_W-1:HALF_W], "R2 row half", m_row, a[ADDR_W-1:HALF_W]);
    chk(m_col == a[HALF_W-1:0], "R3 column half", m_col, a[HALF_W-1:0]);
    chk(ras_no && cas_no, "R7 strobes high at ready", {ras_no, cas_no}, 2'b11);
    if (we) chk(stored(a) == d, "R4 bit written", stored(a), d);
    else    chk(rdata_o == exp_rd, "R5 read data", rdata_o, exp_rd);
    @(negedge clk_i);
    chk(!ready_o, "R6 ready one cycle", ready_o, 0);
    wait_idle();
  endtask

  task automatic t_reset();
    chk(ras_no && cas_no && we_no && !ready_o, "R1 reset outputs",
        {ras_no, cas_no, we_no, ready_o}, 4'b1110);
  endtask

  task automatic t_patterns();
    access(1'b1, 16'h12A5, 1'b1, 1'b0);
    access(1'b1, 16'hA512, 1'b0, 1'b0);
    access(1'b1, 16'h0000, 1'b1, 1'b0);
    access(1'b1, 16'hFFFF, 1'b1, 1'b0);
    access(1'b0, 16'h12A5, 1'b0, 1'b1);
    access(1'b0, 16'hA512, 1'b0, 1'b0);
    access(1'b0, 16'h0000, 1'b0, 1'b1);
    access(1'b0, 16'hFFFF, 1'b0, 1'b1);
    access(1'b1, 16'hFFFF, 1'b0, 1'b0);
    access(1'b0, 16'hFFFF, 1'b0, 1'b0);
  endtask

  // R8: a request raised mid-access leaves no trace
  task automatic t_busy_ignored();
    int falls0, w0, n = 0;
    falls0 = ras_falls; w0 = writes;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 16'h12A5;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1) req_i = 1'b0;
      if (n == 2) begin req_i = 1'b1; we_i = 1'b1; addr_i = 16'h3C3C; wdata_i = 1'b1; end
      if (n == 4) req_i = 1'b0;
    end while (!ready_o && n < 60);
    chk(rdata_o == 1'b1, "R8 first read intact", rdata_o, 1);
    wait_idle();
    wait_idle();
    chk(ras_falls - falls0 == 1, "R8 single row strobe", ras_falls - falls0, 1);
    chk(writes == w0, "R8 no write issued", writes - w0, 0);
    access(1'b0, 16'h3C3C, 1'b0, 1'b0);
  endtask

  // R7: request held from ready; next row strobe waits for precharge
  task automatic t_back_to_back();
    int n = 0;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 16'h5A01; wdata_i = 1'b1;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1) req_i = 1'b0;
    end while (!ready_o && n < 60);
    req_i = 1'b1; we_i = 1'b0; addr_i = 16'h5A01;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (ras_no && n < 60);
    req_i = 1'b0;
    chk(n == T_PRE + 3, "R7 precharge gap", n, T_PRE + 3);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!ready_o && n < 60);
    chk(n == CAS_LAT + 2, "R6 back-to-back latency", n, CAS_LAT + 2);
    chk(rdata_o == 1'b1, "R5 back-to-back read", rdata_o, 1);
    wait_idle();
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_patterns();
    t_busy_ignored();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule